// File: doc/BRIEF.md
# Leaky Bucket Memory Error Monitor

This block measures how often memory errors arrive for each rank. Every rank has two counters, one for correctable errors and one for multi-bit correctable errors. A counter rises by one for each error of its class. A shared, free-running prescaler drains all counters by one at a programmable interval. Because of this drain, only a burst of errors in a short time can push a counter up to the threshold.

When a counter reaches the threshold, the block acts once for that rank. It raises a threshold event and a device-failed event. It then does one of two things, depending on the sparing mode. With sparing enabled, it asserts a spare fail-over request. With sparing disabled, it silences all later correctable-error reports from that rank. Every error that is not silenced produces a report strobe one cycle later, carrying the error's rank and class. Error logging, controller messaging and the data copy of a fail-over are handled by other logic.

Top module: `lbkt_err_monitor`

## Requirements
- R1: Each accepted error adds exactly one to the counter for its rank and class, and a counter never climbs past the threshold value.
- R2: With a nonzero `decay_interval` of N, a decay tick occurs once every N cycles, and each nonzero counter loses one on the tick. An interval of zero stops all decay.
- R3: When an increment and a decay tick hit the same counter in the same cycle, they cancel and the counter keeps its value.
- R4: The correctable class (`err_class` = 0) and the multi-bit class (`err_class` = 1) have independent counters for each rank.
- R5: Each accepted error sets `report_valid` in the next cycle, with `report_rank` and `report_class` copied from the error.
- R6: When an error brings its counter to `threshold`, `thresh_evt` and `failed_evt` pulse together for one cycle in the cycle after that error, with `evt_rank` set to the rank. That error is also reported. With `threshold` = 10, the tenth error in a burst trips and the ninth does not.
- R7: The threshold and failed events fire at most once per rank. Only reset clears this.
- R8: If `spare_en` is 1 when a rank trips, `failover_req` pulses in the same cycle as `thresh_evt`. If `spare_en` is 0, `failover_req` stays low.
- R9: After a rank trips with `spare_en` = 0, later correctable errors on that rank give no report strobe, while multi-bit errors on it are still reported. With sparing enabled, no errors are masked.
- R10: During and right after reset, every output is 0 and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle error pulse |
| err_rank | input | RANK_W | Rank index of the error |
| err_class | input | 1 | 0 = correctable, 1 = multi-bit correctable |
| decay_interval | input | DIV_W | Cycles per decay tick; 0 disables decay |
| threshold | input | CNT_W | Count that triggers the threshold action |
| spare_en | input | 1 | 1 = fail-over on threshold, 0 = mask correctable reports |
| report_valid | output | 1 | Error report strobe |
| report_rank | output | RANK_W | Rank of the reported error |
| report_class | output | 1 | Class of the reported error |
| thresh_evt | output | 1 | Threshold-reached event pulse |
| failed_evt | output | 1 | Device-failed event pulse |
| evt_rank | output | RANK_W | Rank named by the event outputs |
| failover_req | output | 1 | Spare fail-over request pulse |

## Verification
The main stimulus is an interleaved sequence over two ranks and both classes, with decay turned off. This sequence separates per-class counting from a shared counter, masked reports from live ones, and a first trip from a repeated trip. A long burst at threshold 10 checks the exact off-by-one point of the trip. A run with sparing enabled checks that the fail-over request replaces masking. A run that lets the counters drain before more errors arrive shows the difference between a decaying bucket and a plain counter, and it also shows that reset clears the sticky trip state.

// File: rtl/lbkt_pkg.sv
package lbkt_pkg;
  typedef enum logic {ERR_CORR = 1'b0, ERR_MBIT = 1'b1} err_class_e;
  localparam int NUM_CLASSES = 2;

  // Raise a level by one, holding at the ceiling.
  function automatic int bump_level(input int lvl, input int ceil);
    return (lvl >= ceil) ? lvl : lvl + 1;
  endfunction

  // Lower a level by one, holding at zero.
  function automatic int drain_level(input int lvl);
    return (lvl == 0) ? 0 : lvl - 1;
  endfunction
endpackage

// File: rtl/lbkt_decay_timer.sv
module lbkt_decay_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] interval,
  output logic             tick
);
  logic [DIV_W-1:0] pre;

  assign tick = (interval != '0) && (pre >= interval - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || interval == '0 || tick) pre <= '0;
    else                                  pre <= pre + 1'b1;
  end
endmodule

// File: rtl/lbkt_bucket.sv
module lbkt_bucket #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             tick,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] level,
  output logic             hit
);
  import lbkt_pkg::*;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = level;
    if (inc && !tick)      nxt = CNT_W'(bump_level(int'(level), int'(thr)));
    else if (tick && !inc) nxt = CNT_W'(drain_level(int'(level)));
  end

  assign hit = inc && (nxt >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= nxt;
  end
endmodule

// File: rtl/lbkt_rank_policy.sv
module lbkt_rank_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic spare_en,
  output logic trip,
  output logic masked
);
  logic tripped;

  assign trip = hit && !tripped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      masked  <= 1'b0;
    end else if (trip) begin
      tripped <= 1'b1;
      masked  <= !spare_en;
    end
  end
endmodule

// File: rtl/lbkt_err_monitor.sv
module lbkt_err_monitor #(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 5,
  parameter int DIV_W     = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [RANK_W-1:0] err_rank,
  input  logic              err_class,
  input  logic [DIV_W-1:0]  decay_interval,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              spare_en,
  output logic              report_valid,
  output logic [RANK_W-1:0] report_rank,
  output logic              report_class,
  output logic              thresh_evt,
  output logic              failed_evt,
  output logic [RANK_W-1:0] evt_rank,
  output logic              failover_req
);
  import lbkt_pkg::*;
  localparam int NB = NUM_RANKS * NUM_CLASSES;

  // Named internal events, brought out for the checker.
  logic                decay_tick;
  logic                accept;
  logic                any_trip;
  logic [NB-1:0]       bucket_inc;
  logic [NB-1:0]       bucket_hit;
  logic [NB*CNT_W-1:0] bucket_lvl;
  logic [NUM_RANKS-1:0] rank_trip;
  logic [NUM_RANKS-1:0] rank_masked;

  lbkt_decay_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(decay_interval), .tick(decay_tick)
  );

  always_comb begin
    accept = err_valid && (int'(err_rank) < NUM_RANKS);
    if (err_class_e'(err_class) == ERR_CORR && rank_masked[err_rank]) accept = 1'b0;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
      localparam int B = r * NUM_CLASSES + c;
      assign bucket_inc[B] = accept && (err_rank == RANK_W'(r)) && (err_class == 1'(c));
      lbkt_bucket #(.CNT_W(CNT_W)) u_bucket (
        .clk(clk), .rst_n(rst_n), .inc(bucket_inc[B]), .tick(decay_tick),
        .thr(threshold), .level(bucket_lvl[B*CNT_W +: CNT_W]), .hit(bucket_hit[B])
      );
    end
    lbkt_rank_policy u_policy (
      .clk(clk), .rst_n(rst_n),
      .hit(bucket_hit[r*NUM_CLASSES] | bucket_hit[r*NUM_CLASSES+1]),
      .spare_en(spare_en), .trip(rank_trip[r]), .masked(rank_masked[r])
    );
  end

  assign any_trip = |rank_trip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      report_valid <= 1'b0;
      report_rank  <= '0;
      report_class <= 1'b0;
      thresh_evt   <= 1'b0;
      failed_evt   <= 1'b0;
      evt_rank     <= '0;
      failover_req <= 1'b0;
    end else begin
      report_valid <= accept;
      report_rank  <= err_rank;
      report_class <= err_class;
      thresh_evt   <= any_trip;
      failed_evt   <= any_trip;
      failover_req <= any_trip && spare_en;
      if (any_trip) evt_rank <= err_rank;
    end
  end
endmodule

// File: rtl/lbkt_err_monitor_sva.sv
module lbkt_err_monitor_sva #(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 5,
  parameter int RANK_W    = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          decay_tick,
  input logic [NUM_RANKS*2-1:0]        bucket_inc,
  input logic [NUM_RANKS*2*CNT_W-1:0]  bucket_lvl,
  input logic [CNT_W-1:0]              threshold,
  input logic                          spare_en,
  input logic                          report_valid,
  input logic                          thresh_evt,
  input logic                          failed_evt,
  input logic                          failover_req,
  input logic [RANK_W-1:0]             evt_rank
);
  logic [NUM_RANKS-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)          seen <= '0;
    else if (thresh_evt) seen[evt_rank] <= 1'b1;
  end

  for (genvar b = 0; b < NUM_RANKS * 2; b++) begin : g_b
    assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bucket_inc[b] && !decay_tick && bucket_lvl[b*CNT_W +: CNT_W] < threshold)
      |=> bucket_lvl[b*CNT_W +: CNT_W] == CNT_W'($past(bucket_lvl[b*CNT_W +: CNT_W]) + 1'b1));
    assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (decay_tick && !bucket_inc[b] && bucket_lvl[b*CNT_W +: CNT_W] != '0)
      |=> bucket_lvl[b*CNT_W +: CNT_W] == CNT_W'($past(bucket_lvl[b*CNT_W +: CNT_W]) - 1'b1));
    assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (decay_tick && bucket_inc[b]) |=> $stable(bucket_lvl[b*CNT_W +: CNT_W]));
  end

  assert_evt_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_evt |-> (failed_evt && report_valid));
  assert_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_evt |-> !seen[evt_rank]);
  assert_failover_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    failover_req |-> thresh_evt);
  assert_failover_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_evt |-> (failover_req == $past(spare_en)));
endmodule

bind lbkt_err_monitor lbkt_err_monitor_sva #(
  .NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W), .RANK_W(RANK_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .decay_tick(decay_tick), .bucket_inc(bucket_inc),
  .bucket_lvl(bucket_lvl), .threshold(threshold), .spare_en(spare_en),
  .report_valid(report_valid), .thresh_evt(thresh_evt), .failed_evt(failed_evt),
  .failover_req(failover_req), .evt_rank(evt_rank)
);

// File: tb/lbkt_err_monitor_bench.sv
module lbkt_err_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       err_valid;
  logic [2:0] err_rank;
  logic       err_class;
  logic [15:0] decay_interval;
  logic [4:0] threshold;
  logic       spare_en;
  logic       report_valid, report_class, thresh_evt, failed_evt, failover_req;
  logic [2:0] report_rank, evt_rank;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  lbkt_err_monitor u_lbkt_err_monitor (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_rank(err_rank),
    .err_class(err_class), .decay_interval(decay_interval), .threshold(threshold),
    .spare_en(spare_en), .report_valid(report_valid), .report_rank(report_rank),
    .report_class(report_class), .thresh_evt(thresh_evt), .failed_evt(failed_evt),
    .evt_rank(evt_rank), .failover_req(failover_req)
  );

  // Row: rank[5:3], class[2], expected report[1], expected threshold event[0].
  // Threshold 3, sparing off, no decay.
  localparam logic [5:0] VEC [0:9] = '{
    6'b010_0_1_0,  // r2 corr: count 1 (R1 R5)
    6'b010_1_1_0,  // r2 mbit: own counter 1 (R4)
    6'b010_0_1_0,  // r2 corr: 2
    6'b101_0_1_0,  // r5 corr: 1
    6'b010_0_1_1,  // r2 corr: 3 trips (R6)
    6'b010_0_0_0,  // r2 corr masked (R9)
    6'b010_1_1_0,  // r2 mbit still reported (R9)
    6'b010_1_1_0,  // r2 mbit reaches 3, no second event (R7)
    6'b101_1_1_0,  // r5 mbit
    6'b101_0_1_0   // r5 corr: 2, no trip
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] rk, input logic cl);
    @(negedge clk);
    err_valid = 1'b1; err_rank = rk; err_class = cl;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; err_valid = 1'b0; err_rank = '0; err_class = 1'b0;
    decay_interval = '0; threshold = 5'd3; spare_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet under reset.
    check({report_valid, thresh_evt, failed_evt, failover_req} == 4'b0, "R10 reset",
          {report_valid, thresh_evt, failed_evt, failover_req}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      send(VEC[i][5:3], VEC[i][2]);
      check(report_valid == VEC[i][1] &&
            (!VEC[i][1] || (report_rank == VEC[i][5:3] && report_class == VEC[i][2])),
            $sformatf("R5/R9 row %0d report", i), report_valid, VEC[i][1]);
      check(thresh_evt == VEC[i][0] && failed_evt == VEC[i][0] && failover_req == 1'b0 &&
            (!VEC[i][0] || evt_rank == VEC[i][5:3]),
            $sformatf("R6/R7 row %0d event", i), thresh_evt, VEC[i][0]);
    end

    // R6: threshold 10 trips on the tenth error, not the ninth.
    threshold = 5'd10;
    for (int k = 0; k < 8; k++) send(3'd0, 1'b0);
    send(3'd0, 1'b0);
    check(thresh_evt == 1'b0, "R6 ninth error at threshold 10", thresh_evt, 0);
    send(3'd0, 1'b0);
    check(thresh_evt && failed_evt && evt_rank == 3'd0, "R6 tenth error at threshold 10",
          thresh_evt, 1);

    // R8 and R9: sparing replaces masking.
    do_reset();
    threshold = 5'd2; spare_en = 1'b1;
    send(3'd6, 1'b1);
    check(failover_req == 1'b0, "R8 no request before threshold", failover_req, 0);
    send(3'd6, 1'b1);
    check(failover_req && thresh_evt && evt_rank == 3'd6, "R8 failover request",
          failover_req, 1);
    send(3'd6, 1'b0);
    check(report_valid == 1'b1, "R9 no masking with sparing", report_valid, 1);

    // R2: decay drains the bucket; reset cleared rank 2's sticky trip (R7).
    do_reset();
    threshold = 5'd3; spare_en = 1'b0; decay_interval = 16'd20;
    send(3'd2, 1'b0);
    send(3'd2, 1'b0);
    repeat (60) @(negedge clk);
    decay_interval = '0;
    send(3'd2, 1'b0);
    send(3'd2, 1'b0);
    check(thresh_evt == 1'b0, "R2 drained bucket does not trip", thresh_evt, 0);
    repeat (60) @(negedge clk);
    send(3'd2, 1'b0);
    check(thresh_evt == 1'b1 && evt_rank == 3'd2, "R2 zero interval holds count, R7 rearmed",
          thresh_evt, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule